// File: doc/BRIEF.md
# Memory-Mapped I/O Bus Decoder

This block sits behind a simple processor-side bus with a 16-bit address, an active-low select (`sel_n`) and a read/write-not strobe (`rw_n`). Each selected access is steered by address either to a RAM region in the lower part of the space or to a reserved I/O page at the top of the space. The I/O page holds a small peripheral with three 16-bit registers: one control/status word and two data buffers. Any other I/O page address, including odd addresses, is rejected with a one-cycle error flag.

Read data is registered and comes back one clock after the selected read, with `rvalid` marking it. The bus has no back-pressure: the block accepts one access on every clock edge where `sel_n` is low. A read that is not returning data drives `rdata` to zero. The RAM is a reduced-depth synchronous array indexed by the low address bits, so the RAM region aliases with a period of 2^RAM_AW addresses.

Top module: `mmio_bus_decoder`

## Requirements
- R1: After reset, `rdata` is 0, `rvalid` is 0 and `err` is 0.
- R2: While `sel_n` is 1, no RAM word or device register changes whatever `rw_n`, `addr` and `wdata` are, and in the next cycle `rvalid` and `err` are 0.
- R3: Addresses 0 to octal 0167777 are RAM. With `sel_n`=0, `rw_n`=0 writes `wdata` and `rw_n`=1 reads, and a read returns the last value written to that word.
- R4: The RAM word is selected by `addr[RAM_AW-1:0]` only (RAM_AW=6 by default), so RAM addresses that agree in those bits reach the same word.
- R5: The control/status register is at octal 0177160, data buffer 1 at 0177162 and data buffer 2 at 0177164. Each holds a full 16-bit value written to it, resets to 0, and is independent of the other two.
- R6: Addresses octal 0170000 to 0177777 form the I/O page. No access in the I/O page changes any RAM word, and no RAM access changes a device register.
- R7: A selected access to an even I/O page address other than the three device addresses sets `err` for exactly the next cycle, changes no state, and a read there returns `rdata`=0.
- R8: A selected access to any odd I/O page address is treated as in R7.
- R9: `rvalid` is 1 in exactly the cycle after each selected read (`sel_n`=0, `rw_n`=1), and 0 otherwise. The data for that read is on `rdata` in that same cycle.
- R10: `err` stays 0 after any access to the RAM region or to one of the three device registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low access select |
| rw_n | input | 1 | 1 = read, 0 = write (used while `sel_n` is 0) |
| addr | input | 16 | Access address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid when `rvalid` is 1, else 0 |
| rvalid | output | 1 | Read data valid, one cycle after a selected read |
| err | output | 1 | One-cycle flag for a rejected I/O page access |

## Verification
The hardest case to reach from the ports is showing that a rejected I/O access really leaves every piece of state untouched. Nothing an unmapped write could have disturbed is visible until it is read back. The bench therefore writes a marker value to every one of the 4093 unmapped addresses of the I/O page. It then sweeps reads across the whole page and reads back all 64 RAM words and the three device registers against a shadow model. RAM aliasing is exposed by writing through one alias window and reading through the top window, ending at the last RAM address, 0167777.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
  typedef enum logic [1:0] {
    TGT_RAM  = 2'd0,
    TGT_DEV  = 2'd1,
    TGT_NONE = 2'd2
  } tgt_e;
endpackage

// File: rtl/mmio_addr_decode.sv
module mmio_addr_decode
  import mmio_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] IO_BASE = 16'o170000,
  parameter logic [AW-1:0] DEV_BASE = 16'o177160,
  parameter int NUM_DEV = 3,
  localparam int IDX_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic [AW-1:0]    addr,
  output tgt_e             tgt,
  output logic [IDX_W-1:0] dev_idx
);
  logic [NUM_DEV-1:0] hit;

  // one comparator per device register, word-spaced from the base
  for (genvar g = 0; g < NUM_DEV; g++) begin : g_match
    localparam logic [AW-1:0] SLOT = DEV_BASE + AW'(2 * g);
    assign hit[g] = (addr == SLOT);
  end

  always_comb begin
    dev_idx = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (hit[i]) dev_idx = IDX_W'(i);
    end
    if (addr < IO_BASE)  tgt = TGT_RAM;
    else if (|hit)       tgt = TGT_DEV;
    else                 tgt = TGT_NONE;
  end
endmodule

// File: rtl/mmio_ram.sv
module mmio_ram #(
  parameter int DW = 16,
  parameter int RAM_AW = 6,
  localparam int DEPTH = 1 << RAM_AW
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [RAM_AW-1:0] idx,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata_q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) rdata_q <= mem[idx];
  end
endmodule

// File: rtl/mmio_dev_regs.sv
module mmio_dev_regs #(
  parameter int DW = 16,
  parameter int NUM_DEV = 3,
  localparam int IDX_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             re,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata_q
);
  logic [DW-1:0] regs [NUM_DEV];

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        regs[g] <= '0;
      else if (we && idx == IDX_W'(g))   regs[g] <= wdata;
    end
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (idx == IDX_W'(i)) rd_mux = regs[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (re) rdata_q <= rd_mux;
  end
endmodule

// File: rtl/mmio_bus_decoder.sv
module mmio_bus_decoder
  import mmio_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int RAM_AW = 6,
  parameter logic [AW-1:0] IO_BASE = 16'o170000,
  parameter logic [AW-1:0] DEV_BASE = 16'o177160,
  parameter int NUM_DEV = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          rw_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          err
);
  localparam int IDX_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  tgt_e             tgt, tgt_q;
  logic [IDX_W-1:0] dev_idx;
  logic             acc_rd, acc_wr, rd_q, err_q;
  logic [DW-1:0]    ram_q, dev_q;

  assign acc_rd = !sel_n &&  rw_n;
  assign acc_wr = !sel_n && !rw_n;

  mmio_addr_decode #(
    .AW(AW), .IO_BASE(IO_BASE), .DEV_BASE(DEV_BASE), .NUM_DEV(NUM_DEV)
  ) u_dec (
    .addr(addr), .tgt(tgt), .dev_idx(dev_idx)
  );

  mmio_ram #(.DW(DW), .RAM_AW(RAM_AW)) u_ram (
    .clk(clk),
    .we(acc_wr && tgt == TGT_RAM),
    .re(acc_rd && tgt == TGT_RAM),
    .idx(addr[RAM_AW-1:0]),
    .wdata(wdata),
    .rdata_q(ram_q)
  );

  mmio_dev_regs #(.DW(DW), .NUM_DEV(NUM_DEV)) u_dev (
    .clk(clk),
    .rst_n(rst_n),
    .we(acc_wr && tgt == TGT_DEV),
    .re(acc_rd && tgt == TGT_DEV),
    .idx(dev_idx),
    .wdata(wdata),
    .rdata_q(dev_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      err_q <= 1'b0;
      tgt_q <= TGT_NONE;
    end else begin
      rd_q  <= acc_rd;
      err_q <= !sel_n && tgt == TGT_NONE;
      tgt_q <= tgt;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_q) begin
      case (tgt_q)
        TGT_RAM: rdata = ram_q;
        TGT_DEV: rdata = dev_q;
        default: rdata = '0;
      endcase
    end
  end

  assign rvalid = rd_q;
  assign err    = err_q;
endmodule

// File: rtl/mmio_bus_decoder_chk.sv
module mmio_bus_decoder_chk #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter logic [AW-1:0] IO_BASE = 16'o170000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel_n,
  input logic          rw_n,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] rdata,
  input logic          rvalid,
  input logic          err
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> (!rvalid && !err)); // R2
  AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && rw_n) |=> rvalid); // R9
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sel_n && rw_n) |=> !rvalid); // R9
  AST_RAM_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && addr < IO_BASE) |=> !err); // R10
  AST_ODD_IO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && addr >= IO_BASE && addr[0]) |=> err); // R8
  AST_ERR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && err) |-> (rdata == '0)); // R7
endmodule

bind mmio_bus_decoder mmio_bus_decoder_chk #(
  .AW(AW), .DW(DW), .IO_BASE(IO_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rw_n(rw_n), .addr(addr),
  .rdata(rdata), .rvalid(rvalid), .err(err)
);

// File: tb/mmio_bus_decoder_test.sv
module mmio_bus_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1;
  logic        rw_n = 1'b1;
  logic [15:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rvalid, err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [15:0] ram_m [64];
  logic [15:0] dev_m [3];

  always #5 clk = ~clk;

  mmio_bus_decoder uut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rw_n(rw_n), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .err(err)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access: drive at a falling edge, sample at the next falling edge
  task automatic access(input logic rd, input logic [15:0] a, input logic [15:0] d,
                        output logic [15:0] q, output logic v, output logic e);
    @(negedge clk);
    sel_n = 1'b0; rw_n = rd; addr = a; wdata = d;
    @(negedge clk);
    q = rdata; v = rvalid; e = err;
    sel_n = 1'b1; rw_n = 1'b1;
  endtask

  function automatic int dev_slot(input logic [15:0] a);
    if (a == 16'o177160) return 0;
    if (a == 16'o177162) return 1;
    if (a == 16'o177164) return 2;
    return -1;
  endfunction

  initial begin
    logic [15:0] q;
    logic v, e;
    repeat (3) @(negedge clk);
    chk("R1 rdata", rdata, 16'h0);
    chk("R1 rvalid", {15'b0, rvalid}, 16'h0);
    chk("R1 err", {15'b0, err}, 16'h0);
    rst_n = 1'b1;

    // R3/R4: fill RAM through the bottom window, read through the top window
    for (int i = 0; i < 64; i++) begin
      ram_m[i] = 16'(i * 16'h0101) ^ 16'hA5C3;
      access(1'b0, 16'(i), ram_m[i], q, v, e);
      chk("R10 ram write err", {15'b0, e}, 16'h0);
      chk("R9 write no valid", {15'b0, v}, 16'h0);
    end
    for (int i = 0; i < 64; i++) begin
      access(1'b1, 16'o167700 + 16'(i), 16'h0, q, v, e);
      chk("R4 alias read", q, ram_m[i]);
      chk("R9 read valid", {15'b0, v}, 16'h1);
      chk("R10 ram read err", {15'b0, e}, 16'h0);
    end
    // R3: rewrite one word at a mid-range address and read it back directly
    ram_m[16'o52345 & 63] = 16'h1234;
    access(1'b0, 16'o52345, 16'h1234, q, v, e);
    access(1'b1, 16'o52345, 16'h0, q, v, e);
    chk("R3 rewrite", q, 16'h1234);

    // R5: reset values, then distinct writes
    for (int i = 0; i < 3; i++) begin
      access(1'b1, 16'o177160 + 16'(2 * i), 16'h0, q, v, e);
      chk("R5 reset value", q, 16'h0);
    end
    for (int i = 0; i < 3; i++) begin
      dev_m[i] = 16'hC000 + 16'(i * 16'h1111);
      access(1'b0, 16'o177160 + 16'(2 * i), dev_m[i], q, v, e);
      chk("R10 dev write err", {15'b0, e}, 16'h0);
    end
    dev_m[1] = 16'hFFFF;
    access(1'b0, 16'o177162, 16'hFFFF, q, v, e);
    for (int i = 0; i < 3; i++) begin
      access(1'b1, 16'o177160 + 16'(2 * i), 16'h0, q, v, e);
      chk("R5 dev readback", q, dev_m[i]);
      chk("R10 dev read err", {15'b0, e}, 16'h0);
    end

    // R7/R8: write a marker to every unmapped I/O page address
    for (int a = 16'o170000; a <= 16'o177777; a++) begin
      if (dev_slot(16'(a)) < 0) begin
        access(1'b0, 16'(a), 16'hDEAD, q, v, e);
        chk(a[0] ? "R8 odd write err" : "R7 unmapped write err", {15'b0, e}, 16'h1);
      end
    end
    // full read sweep of the I/O page
    for (int a = 16'o170000; a <= 16'o177777; a++) begin
      access(1'b1, 16'(a), 16'h0, q, v, e);
      if (dev_slot(16'(a)) >= 0) begin
        chk("R5 dev after sweep", q, dev_m[dev_slot(16'(a))]);
        chk("R10 dev no err", {15'b0, e}, 16'h0);
      end else begin
        chk(a[0] ? "R8 odd read data" : "R7 unmapped read data", q, 16'h0);
        chk(a[0] ? "R8 odd read err" : "R7 unmapped read err", {15'b0, e}, 16'h1);
        chk("R9 err read valid", {15'b0, v}, 16'h1);
      end
    end
    // R6: RAM untouched by I/O traffic
    for (int i = 0; i < 64; i++) begin
      access(1'b1, 16'(i), 16'h0, q, v, e);
      chk("R6 ram after io", q, ram_m[i]);
    end

    // R2: unselected cycles with write strobe on RAM and device addresses
    @(negedge clk);
    rw_n = 1'b0; addr = 16'h0005; wdata = 16'h0BAD;
    @(negedge clk);
    chk("R2 idle valid", {15'b0, rvalid}, 16'h0);
    chk("R2 idle err", {15'b0, err}, 16'h0);
    addr = 16'o177160;
    @(negedge clk);
    addr = 16'o170002;
    @(negedge clk);
    chk("R2 idle err io", {15'b0, err}, 16'h0);
    rw_n = 1'b1;
    access(1'b1, 16'h0005, 16'h0, q, v, e);
    chk("R2 ram unchanged", q, ram_m[5]);
    access(1'b1, 16'o177160, 16'h0, q, v, e);
    chk("R2 dev unchanged", q, dev_m[0]);

    // R6: RAM write at the last RAM address leaves device registers alone
    ram_m[63] = 16'h7E7E;
    access(1'b0, 16'o167777, 16'h7E7E, q, v, e);
    access(1'b1, 16'o177164, 16'h0, q, v, e);
    chk("R6 dev after ram", q, dev_m[2]);
    access(1'b1, 16'o167777, 16'h0, q, v, e);
    chk("R3 top ram word", q, 16'h7E7E);
    @(negedge clk);
    chk("R9 valid drops", {15'b0, rvalid}, 16'h0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1_900_000;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule